// File: doc/BRIEF.md
# Fixed-Point to Sign-Magnitude Float Normalizer

This block turns a signed fixed-point sample into a compact 16-bit floating-point word. The input is a 16-bit two's-complement number with 5 fractional bits, so one code step is worth 2^-5. The output word holds a sign, a 9-bit fractional mantissa and a signed exponent. The exponent is kept as a sign bit plus a 5-bit magnitude and has no bias. The mantissa is a pure fraction that keeps its leading 1. The encoded value is M × 2^E with 0.5 ≤ M < 1.

To get there, the block takes the absolute value of the input in a register one bit wider than the input magnitude. It then locates the leading one, shifts it into the top mantissa position and derives the exponent from its position. It rounds on the first bit that falls off the mantissa. If that rounding carries out of the mantissa, it renormalizes.

A producer presents a sample with `in_valid`. The sample is taken in any cycle in which `in_ready` is also high. The converted word appears on `out_data` one clock later, qualified by `out_valid` for exactly that one cycle.

Top module: `fxfl_normalizer`

## Requirements
- R1: The output word is laid out, from bit 15 down, as: mantissa sign (bit 15), mantissa fraction (bits 14..6), exponent sign (bit 5), exponent magnitude (bits 4..0).
- R2: For every nonzero input, mantissa bit 14 (the weight-1/2 bit) is 1.
- R3: For every input code, the encoded value (mantissa/512) × 2^E equals the input magnitude/32, rounded to 9 mantissa bits as R6 describes.
- R4: The exponent is sign-magnitude: exponent sign 0 means positive and 1 means negative. A zero exponent is written as sign 0 with magnitude 0. Every produced exponent lies in [-4, +11].
- R5: The mantissa sign is 1 exactly when the input is negative, and the mantissa field carries only the magnitude. The most negative input code 0x8000 yields 0xC00B (mantissa .100000000, exponent +11).
- R6: When magnitude bits fall below the mantissa, the mantissa is incremented if the first dropped bit is 1 and is left unchanged if that bit is 0. For example, 0x03FD and 0x03FE both give 0x7FC5, and 0x03FC gives 0x7F85.
- R7: When rounding carries out of the mantissa, the mantissa becomes .100000000 and the exponent rises by one. For example, 0x03FF (31.96875) gives 0x4006.
- R8: A zero input yields the all-zero output word. This is the only word whose mantissa bit 14 is 0.
- R9: `in_ready` is low during reset and high afterwards. An accepted sample produces `out_valid` high in the next cycle. A cycle without acceptance is followed by `out_valid` low, and `out_data` keeps its last value.
- R10: 7.0 (0x00E0) gives mantissa .111000000 with exponent +3 (0x7003). 0.25 (0x0008) gives mantissa .100000000 with exponent -1 (0x4021).
- R11: While reset is asserted, `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A fixed-point sample is offered |
| in_ready | output | 1 | The block takes the offered sample this cycle |
| in_data | input | 16 | Two's-complement fixed-point sample, 5 fractional bits |
| out_valid | output | 1 | `out_data` holds a fresh result this cycle |
| out_data | output | 16 | Floating-point word: sign, mantissa, exponent sign, exponent magnitude |

## Verification
The hardest situation to reach from the ports is the rounding carry that forces renormalization. It happens only when every kept mantissa bit is 1 and the first dropped bit is also 1. Among leading-one positions of 9 or more, few codes meet that condition, so random stimulus hits it rarely. The bench drives every one of the 65,536 input codes back to back and compares each result with a behavioural model, which covers every carry case and every exponent value. Directed samples pin down the carry and truncation neighbours around 0x03FF, the most negative code, and zero. Idle cycles are inserted into the sweep with changing data so that the hold behaviour is checked too.

// File: rtl/fxfl_pkg.sv
package fxfl_pkg;
  // default number format
  localparam int unsigned DEF_FX_W    = 16;  // fixed-point width, incl. sign
  localparam int unsigned DEF_FX_FRAC = 5;   // fractional bits of the input
  localparam int unsigned DEF_MAN_W   = 9;   // explicit mantissa bits
  localparam int unsigned DEF_EXM_W   = 5;   // exponent magnitude bits

  // signed exponent for a leading one at bit position pos of the magnitude
  function automatic int lead_exponent(int pos, int frac_w, bit carry);
    return pos + 1 - frac_w + (carry ? 1 : 0);
  endfunction

  // magnitude part of a sign-magnitude exponent
  function automatic int exp_magnitude(int e);
    return (e < 0) ? -e : e;
  endfunction
endpackage

// File: rtl/fxfl_abs.sv
module fxfl_abs #(
  parameter int unsigned W = fxfl_pkg::DEF_FX_W
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] mag,
  output logic         neg
);
  // unsigned W-bit result is one bit wider than the W-1 magnitude bits,
  // so the most negative code maps to 2^(W-1) without overflow
  always_comb begin
    neg = x[W-1];
    mag = neg ? (~x + W'(1)) : x;
  end
endmodule

// File: rtl/fxfl_lead.sv
module fxfl_lead #(
  parameter int unsigned W = fxfl_pkg::DEF_FX_W,
  localparam int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0]  v,
  output logic [PW-1:0] pos,
  output logic          found
);
  // highest set bit wins
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (v[i]) begin
        pos   = PW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fxfl_norm_round.sv
module fxfl_norm_round #(
  parameter int unsigned W     = fxfl_pkg::DEF_FX_W,
  parameter int unsigned FRAC  = fxfl_pkg::DEF_FX_FRAC,
  parameter int unsigned MAN_W = fxfl_pkg::DEF_MAN_W,
  parameter int unsigned EXM_W = fxfl_pkg::DEF_EXM_W,
  localparam int unsigned PW   = $clog2(W)
) (
  input  logic [W-1:0]     mag,
  input  logic [PW-1:0]    pos,
  input  logic             found,
  output logic [MAN_W-1:0] mant,
  output logic             e_sign,
  output logic [EXM_W-1:0] e_mag,
  output logic             rnd_up,
  output logic             rnd_carry
);
  logic [W-1:0]     shifted;
  logic [MAN_W-1:0] kept;
  logic             guard;
  logic [MAN_W:0]   summed;
  int               e_i;

  // leading one moved to the top bit
  assign shifted = mag << (PW'(W - 1) - pos);
  assign kept    = shifted[W-1 -: MAN_W];

  generate
    if (W > MAN_W) begin : g_guard
      assign guard = shifted[W-1-MAN_W];
    end else begin : g_noguard
      assign guard = 1'b0;
    end
  endgenerate

  assign summed    = {1'b0, kept} + {{MAN_W{1'b0}}, guard};
  assign rnd_up    = found & guard;
  assign rnd_carry = found & summed[MAN_W];

  always_comb begin
    e_i = fxfl_pkg::lead_exponent(int'(pos), int'(FRAC), rnd_carry);
    if (!found) begin
      mant   = '0;
      e_sign = 1'b0;
      e_mag  = '0;
    end else begin
      mant   = rnd_carry ? {1'b1, {(MAN_W-1){1'b0}}} : summed[MAN_W-1:0];
      e_sign = (e_i < 0);
      e_mag  = EXM_W'(fxfl_pkg::exp_magnitude(e_i));
    end
  end

  // a carry out of the mantissa can only come from an increment
  always_comb begin
    if (found) begin
      AST_CARRY_NEEDS_ROUND: assert (!rnd_carry || rnd_up); // R6
      AST_CARRY_ALL_ONES: assert (!rnd_carry || (&kept)); // R7
    end
  end
endmodule

// File: rtl/fxfl_normalizer.sv
module fxfl_normalizer #(
  parameter int unsigned W     = fxfl_pkg::DEF_FX_W,
  parameter int unsigned FRAC  = fxfl_pkg::DEF_FX_FRAC,
  parameter int unsigned MAN_W = fxfl_pkg::DEF_MAN_W,
  parameter int unsigned EXM_W = fxfl_pkg::DEF_EXM_W,
  localparam int unsigned OUT_W = MAN_W + EXM_W + 2,
  localparam int unsigned PW    = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int unsigned EXP_POS_MAX = W - FRAC;  // leading one at top bit
  localparam int unsigned EXP_NEG_MAX = FRAC - 1;  // leading one at bit 0

  logic [W-1:0]     mag;
  logic             neg;
  logic [PW-1:0]    pos;
  logic             found;
  logic [MAN_W-1:0] mant;
  logic             e_sign;
  logic [EXM_W-1:0] e_mag;
  logic             rnd_up;
  logic             rnd_carry;
  logic             accept;
  logic [OUT_W-1:0] next_word;
  logic             rdy_q;
  logic             vld_q;
  logic [OUT_W-1:0] word_q;

  fxfl_abs #(.W(W)) abs_i (
    .x   (in_data),
    .mag (mag),
    .neg (neg)
  );

  fxfl_lead #(.W(W)) lead_i (
    .v     (mag),
    .pos   (pos),
    .found (found)
  );

  fxfl_norm_round #(
    .W     (W),
    .FRAC  (FRAC),
    .MAN_W (MAN_W),
    .EXM_W (EXM_W)
  ) norm_i (
    .mag       (mag),
    .pos       (pos),
    .found     (found),
    .mant      (mant),
    .e_sign    (e_sign),
    .e_mag     (e_mag),
    .rnd_up    (rnd_up),
    .rnd_carry (rnd_carry)
  );

  assign accept    = in_valid & rdy_q;
  assign next_word = found ? {neg, mant, e_sign, e_mag} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      vld_q <= accept;
      if (accept) begin
        word_q <= next_word;
      end
    end
  end

  assign in_ready  = rdy_q;
  assign out_valid = vld_q;
  assign out_data  = word_q;

  AST_MANT_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data != '0) |-> out_data[OUT_W-2]); // R2

  AST_ZERO_ONLY_UNNORM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_data[OUT_W-2]) |-> (out_data == '0)); // R8

  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[EXM_W] ? (out_data[EXM_W-1:0] <= EXM_W'(EXP_NEG_MAX))
                                   : (out_data[EXM_W-1:0] <= EXM_W'(EXP_POS_MAX)))); // R4

  AST_NO_NEG_ZERO_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data[EXM_W]) |-> (out_data[EXM_W-1:0] != '0)); // R4

  AST_SIGN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_data[OUT_W-1] == $past(in_data[W-1]))); // R5

  AST_CARRY_RENORM: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rnd_carry) |=> (out_data[OUT_W-2 -: MAN_W] == {1'b1, {(MAN_W-1){1'b0}}})); // R7

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (!out_valid && $stable(out_data))); // R9

  AST_RST_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_data == '0 && !in_ready)); // R11
endmodule

// File: tb/fxfl_normalizer_tb.sv
`timescale 1ns/1ps
module fxfl_normalizer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = 16'h0;
  logic        out_valid;
  logic [15:0] out_data;

  int          checks = 0;
  int          errors = 0;
  logic [15:0] last_word = 16'h0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fxfl_normalizer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // behavioural model: search the exponent, scale, round, renormalize
  function automatic logic [15:0] model(logic [15:0] x);
    int v, mag, e, m, sh;
    bit s, rb;
    v   = int'($signed(x));
    s   = (v < 0);
    mag = s ? -v : v;
    if (mag == 0) return 16'h0;
    e = -4;
    while ((1 << (e + 5)) <= mag) e++;
    sh = 4 - e;
    if (sh >= 0) begin
      m  = mag << sh;
      rb = 1'b0;
    end else begin
      m  = mag >> (-sh);
      rb = ((mag >> (-sh - 1)) & 1) != 0;
    end
    if (rb) m++;
    if (m == 512) begin
      m = 256;
      e++;
    end
    return {s, 9'(m), (e < 0), 5'((e < 0) ? -e : e)};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic cycle_in(bit v, logic [15:0] d, string req);
    bit          acc;
    logic [15:0] e;
    bit          in_rng;
    in_valid = v;
    in_data  = d;
    acc      = v && (in_ready === 1'b1);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R9 valid"}, {15'h0, out_valid}, {15'h0, acc});
    if (acc) begin
      e = model(d);
      last_word = e;
      chk(req, out_data, e);
      // R4 range and R2 normalization on every produced word
      in_rng = out_data[5] ? (out_data[4:0] <= 5'd4 && out_data[4:0] != 5'd0)
                           : (out_data[4:0] <= 5'd11);
      chk("R4 exponent range", {15'h0, in_rng}, 16'h1);
      if (d != 16'h0) chk("R2 leading mantissa bit", {15'h0, out_data[14]}, 16'h1);
    end else begin
      chk({req, " R9 hold"}, out_data, last_word);
    end
  endtask

  task automatic directed(logic [15:0] d, logic [15:0] exp, string req);
    cycle_in(1'b1, d, req);
    chk({req, " directed"}, out_data, exp);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 out_valid in reset", {15'h0, out_valid}, 16'h0);
    chk("R11 out_data in reset", out_data, 16'h0);
    chk("R9 in_ready in reset", {15'h0, in_ready}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 in_ready after reset", {15'h0, in_ready}, 16'h1);

    // R10 worked cases and R1 field layout
    directed(16'h00E0, 16'h7003, "R10 seven");
    chk("R1 mantissa field", {7'h0, out_data[14:6]}, 16'h01C0);
    chk("R1 exponent sign field", {15'h0, out_data[5]}, 16'h0);
    chk("R1 exponent magnitude field", {11'h0, out_data[4:0]}, 16'h0003);
    directed(16'h0008, 16'h4021, "R10 quarter");
    chk("R4 negative exponent sign", {15'h0, out_data[5]}, 16'h1);
    // R8 zero
    directed(16'h0000, 16'h0000, "R8 zero");
    // R5 sign handling
    directed(16'h8000, 16'hC00B, "R5 most negative");
    directed(16'hFF20, 16'hF003, "R5 minus seven");
    // R6 rounding by first dropped bit
    directed(16'h03FD, 16'h7FC5, "R6 round up");
    directed(16'h03FE, 16'h7FC5, "R6 truncate");
    directed(16'h03FC, 16'h7F85, "R6 truncate low");
    // R7 carry renormalization
    directed(16'h03FF, 16'h4006, "R7 carry");
    directed(16'hFC01, 16'hC006, "R7 carry negative");
    // R9 idle cycles with changing data keep the output
    cycle_in(1'b0, 16'h1234, "R9 idle");
    cycle_in(1'b0, 16'h8000, "R9 idle");
    // R3 exhaustive sweep with sparse idle cycles
    for (int k = 0; k < 65536; k++) begin
      cycle_in(1'b1, 16'(k), "R3 sweep");
      if ((k % 97) == 0) cycle_in(1'b0, 16'(k ^ 16'h5A5A), "R9 gap");
    end
    in_valid = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule